// File: doc/BRIEF.md
# LCD Common Scan and Drive-Level Generator

This block sequences the common scan of a dot-matrix panel with 80 common lines and 132 segment lines. Each pulse of the display clock enable (`tick`) fetches one line of pixel data through a line-read port and latches it. The block then advances to the next scan position. A duty setting fixes how many lines make up one frame, from 8 to 80 in steps of 8. The alternation signal toggles once per frame.

Two offsets place the picture. The start line offset picks which RAM line is scanned first, and the start common offset picks which common driver carries that first line. A direction bit mirrors the common order. From the latched line, the alternation phase and the mode controls, the block produces a 2-bit drive-level code for every common and every segment output. The controls are invert, blank, power-save and master/slave. An analog stage outside the block turns those codes into voltages.

Top module: `lcd_scan_drive`

## Requirements
- R1: The frame length in ticks is 8 × `duty_sel` when `duty_sel` is 1 to 10. Any other value gives 80. `fr_out` inverts on the tick that ends a frame and holds at every other edge.
- R2: `rd_line` equals (`start_line` + scan position) mod 80. The scan position starts at 0 after reset and rises by one per tick until the frame wraps.
- R3: On a tick, the scan position k is latched as the selected common. In normal order (`com_rev`=0) this is (`start_com` + k) mod 80. In reversed order it is 79 − ((`start_com` + k) mod 80). Exactly one common is selected once a tick has occurred.
- R4: Segment code for latched pixel p and latched alternation phase f: p=1,f=1 → 1 (V1); p=1,f=0 → 0 (VSS); p=0,f=1 → 2 (V3); p=0,f=0 → 3 (V4). Segment j uses bits [2j+1:2j].
- R5: Common code for selected s and phase f: s=1,f=1 → 0 (VSS); s=1,f=0 → 1 (V1); s=0,f=1 → 2 (V2); s=0,f=0 → 3 (V5). Common i uses bits [2i+1:2i]. Commons outside the active window carry the unselected code.
- R6: While `power_save` is 1, every common and segment code is 0 (VSS).
- R7: `invert`=1 uses the complement of the latched pixel. The change takes effect at once, without a new tick.
- R8: Blank (`disp_off` as master, `doff_in` as slave) forces every pixel to 0 in the segment encoding. The latched data is kept, so the picture returns when blank is released.
- R9: With `master`=0, the alternation phase latched on each tick comes from `fr_in` and blanking comes from `doff_in`. With `master`=1, they come from the internal frame toggle and `disp_off`.
- R10: After reset, the scan position and alternation phase are 0, no common is selected and the latched pixels are 0.
- R11: Without a tick, the scan position, the latched line and `fr_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Display clock enable, one common line per pulse |
| master | input | 1 | 1: internal alternation and blank; 0: taken from inputs |
| fr_in | input | 1 | Alternation phase from a master device |
| doff_in | input | 1 | Blank request from a master device |
| duty_sel | input | 4 | Frame length in units of 8 lines |
| start_line | input | 7 | First RAM line of the frame |
| start_com | input | 7 | Common driver that carries the first line |
| com_rev | input | 1 | Reverse common order |
| invert | input | 1 | Show inverted pixels |
| disp_off | input | 1 | Blank request in master mode |
| power_save | input | 1 | Drive every output to VSS |
| rd_data | input | 132 | Pixel data of line `rd_line`, valid in the same cycle |
| rd_line | output | 7 | RAM line being requested |
| fr_out | output | 1 | Internal alternation phase |
| doff_out | output | 1 | Blank request forwarded to a slave |
| com_code | output | 160 | Drive-level code per common |
| seg_code | output | 264 | Drive-level code per segment |

## Verification
`rd_line` and `fr_out` come from the scan registers, so they take a tick's effect at the clock edge that samples it. The latched line, the selected common and the latched phase are also written at that edge, so the common and segment codes change one edge after the tick is presented. Invert, blank and power-save are combinational on the latches and act in the same cycle. The bench drives every input at the falling edge. It advances its behavioural model right after the rising edge, using the inputs that edge saw. It then compares all outputs at the next falling edge. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/lcd_drive_pkg.sv
`timescale 1ns/1ps
package lcd_drive_pkg;

  typedef enum logic [1:0] {
    LV_VSS  = 2'd0,
    LV_TOP  = 2'd1,
    LV_MIDU = 2'd2,
    LV_MIDL = 2'd3
  } lvl_t;

  // modular sum of two non-negative indices
  function automatic int wrap_add(input int a, input int b, input int m);
    return (a + b) % m;
  endfunction

  // lines per frame for a duty code; out-of-range codes give the full panel
  function automatic int duty_lines(input int code, input int step, input int max_code);
    if (code < 1 || code > max_code) return max_code * step;
    return code * step;
  endfunction

  function automatic lvl_t seg_level(input logic pix, input logic fr);
    case ({pix, fr})
      2'b11:   return LV_TOP;
      2'b10:   return LV_VSS;
      2'b01:   return LV_MIDU;
      default: return LV_MIDL;
    endcase
  endfunction

  function automatic lvl_t com_level(input logic sel, input logic fr);
    case ({sel, fr})
      2'b11:   return LV_VSS;
      2'b10:   return LV_TOP;
      2'b01:   return LV_MIDU;
      default: return LV_MIDL;
    endcase
  endfunction

endpackage

// File: rtl/lcd_scan_seq.sv
`timescale 1ns/1ps
module lcd_scan_seq #(
  parameter int N_COM     = 80,
  parameter int LINE_STEP = 8,
  parameter int AW        = $clog2(N_COM),
  parameter int DW        = $clog2(N_COM / LINE_STEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] duty_sel,
  output logic [AW-1:0] scan_pos,
  output logic          fr_cur,
  output logic          wrap_evt
);
  import lcd_drive_pkg::*;

  localparam int MAX_CODE = N_COM / LINE_STEP;

  int  frame_lines;
  logic last_pos;

  always_comb begin
    frame_lines = duty_lines(int'(duty_sel), LINE_STEP, MAX_CODE);
    last_pos    = int'(scan_pos) >= frame_lines - 1;
    wrap_evt    = tick && last_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_pos <= '0;
      fr_cur   <= 1'b0;
    end else if (tick) begin
      if (last_pos) begin
        scan_pos <= '0;
        fr_cur   <= ~fr_cur;
      end else begin
        scan_pos <= scan_pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_com_drive.sv
`timescale 1ns/1ps
module lcd_com_drive #(
  parameter int N_COM = 80,
  parameter int AW    = $clog2(N_COM)
) (
  input  logic             valid,
  input  logic [AW-1:0]    act_com,
  input  logic             fr,
  input  logic             power_save,
  output logic [N_COM-1:0] com_sel,
  output logic [2*N_COM-1:0] com_code
);
  import lcd_drive_pkg::*;

  for (genvar i = 0; i < N_COM; i++) begin : g_com
    always_comb begin
      com_sel[i] = valid && (int'(act_com) == i);
      com_code[2*i +: 2] = power_save ? LV_VSS : com_level(com_sel[i], fr);
    end
  end

endmodule

// File: rtl/lcd_seg_drive.sv
`timescale 1ns/1ps
module lcd_seg_drive #(
  parameter int N_SEG = 132
) (
  input  logic [N_SEG-1:0]   lat_data,
  input  logic               invert,
  input  logic               blank,
  input  logic               fr,
  input  logic               power_save,
  output logic [2*N_SEG-1:0] seg_code
);
  import lcd_drive_pkg::*;

  for (genvar j = 0; j < N_SEG; j++) begin : g_seg
    logic pix;
    always_comb begin
      pix = blank ? 1'b0 : (lat_data[j] ^ invert);
      seg_code[2*j +: 2] = power_save ? LV_VSS : seg_level(pix, fr);
    end
  end

endmodule

// File: rtl/lcd_scan_drive.sv
`timescale 1ns/1ps
module lcd_scan_drive #(
  parameter int N_COM     = 80,
  parameter int N_SEG     = 132,
  parameter int LINE_STEP = 8,
  localparam int AW       = $clog2(N_COM),
  localparam int DW       = $clog2(N_COM / LINE_STEP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               master,
  input  logic               fr_in,
  input  logic               doff_in,
  input  logic [DW-1:0]      duty_sel,
  input  logic [AW-1:0]      start_line,
  input  logic [AW-1:0]      start_com,
  input  logic               com_rev,
  input  logic               invert,
  input  logic               disp_off,
  input  logic               power_save,
  input  logic [N_SEG-1:0]   rd_data,
  output logic [AW-1:0]      rd_line,
  output logic               fr_out,
  output logic               doff_out,
  output logic [2*N_COM-1:0] com_code,
  output logic [2*N_SEG-1:0] seg_code
);
  import lcd_drive_pkg::*;

  logic [AW-1:0]    scan_pos;
  logic             fr_cur;
  logic             wrap_evt;
  logic [AW-1:0]    phys_com;
  logic [N_SEG-1:0] lat_data;
  logic [AW-1:0]    lat_com;
  logic             lat_fr;
  logic             lat_valid;
  logic             blank;
  logic [N_COM-1:0] com_sel;

  lcd_scan_seq #(.N_COM(N_COM), .LINE_STEP(LINE_STEP), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .duty_sel(duty_sel),
    .scan_pos(scan_pos), .fr_cur(fr_cur), .wrap_evt(wrap_evt)
  );

  // line and common addressing for the current scan position
  always_comb begin
    int base;
    rd_line  = AW'(wrap_add(int'(start_line), int'(scan_pos), N_COM));
    base     = wrap_add(int'(start_com), int'(scan_pos), N_COM);
    phys_com = com_rev ? AW'(N_COM - 1 - base) : AW'(base);
    blank    = master ? disp_off : doff_in;
  end

  // line latch: holds the line shown until the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_data  <= '0;
      lat_com   <= '0;
      lat_fr    <= 1'b0;
      lat_valid <= 1'b0;
    end else if (tick) begin
      lat_data  <= rd_data;
      lat_com   <= phys_com;
      lat_fr    <= master ? fr_cur : fr_in;
      lat_valid <= 1'b1;
    end
  end

  lcd_com_drive #(.N_COM(N_COM), .AW(AW)) u_com (
    .valid(lat_valid), .act_com(lat_com), .fr(lat_fr), .power_save(power_save),
    .com_sel(com_sel), .com_code(com_code)
  );

  lcd_seg_drive #(.N_SEG(N_SEG)) u_seg (
    .lat_data(lat_data), .invert(invert), .blank(blank), .fr(lat_fr),
    .power_save(power_save), .seg_code(seg_code)
  );

  assign fr_out   = fr_cur;
  assign doff_out = disp_off;

endmodule

// File: rtl/lcd_scan_drive_chk.sv
`timescale 1ns/1ps
module lcd_scan_drive_chk #(
  parameter int N_COM = 80,
  parameter int N_SEG = 132,
  parameter int AW    = $clog2(N_COM)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               power_save,
  input logic               wrap_evt,
  input logic               fr_out,
  input logic               lat_valid,
  input logic [AW-1:0]      scan_pos,
  input logic [AW-1:0]      rd_line,
  input logic [N_COM-1:0]   com_sel,
  input logic [2*N_COM-1:0] com_code,
  input logic [2*N_SEG-1:0] seg_code
);

  p_fr_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (fr_out != $past(fr_out)));

  p_fr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(fr_out));

  p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_line) < N_COM);

  p_one_com_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid |-> ($countones(com_sel) == 1));

  p_at_most_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));

  p_all_vss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    power_save |-> (com_code == '0 && seg_code == '0));

  p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(scan_pos));

endmodule

bind lcd_scan_drive lcd_scan_drive_chk #(.N_COM(N_COM), .N_SEG(N_SEG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .power_save(power_save),
  .wrap_evt(wrap_evt), .fr_out(fr_out), .lat_valid(lat_valid),
  .scan_pos(scan_pos), .rd_line(rd_line), .com_sel(com_sel),
  .com_code(com_code), .seg_code(seg_code)
);

// File: tb/lcd_scan_drive_test.sv
`timescale 1ns/1ps
module lcd_scan_drive_test;
  localparam int NC = 80;
  localparam int NS = 132;

  logic clk = 1'b0;
  logic rst_n, tick, master, fr_in, doff_in, com_rev, invert, disp_off, power_save;
  logic [3:0]      duty_sel;
  logic [6:0]      start_line, start_com;
  logic [NS-1:0]   rd_data;
  logic [6:0]      rd_line;
  logic            fr_out, doff_out;
  logic [2*NC-1:0] com_code;
  logic [2*NS-1:0] seg_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_scan_drive uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .master(master), .fr_in(fr_in),
    .doff_in(doff_in), .duty_sel(duty_sel), .start_line(start_line),
    .start_com(start_com), .com_rev(com_rev), .invert(invert),
    .disp_off(disp_off), .power_save(power_save), .rd_data(rd_data),
    .rd_line(rd_line), .fr_out(fr_out), .doff_out(doff_out),
    .com_code(com_code), .seg_code(seg_code)
  );

  function automatic bit pat(int line, int j);
    return ((line * 5 + j * 3 + line * j) % 7) < 3;
  endfunction

  // RAM stand-in answering the line-read port
  always_comb
    for (int j = 0; j < NS; j++) rd_data[j] = pat(int'(rd_line), j);

  // behavioural reference state
  int k = 0, fr_m = 0, m_com = 0, m_fr = 0, m_valid = 0;
  bit [NS-1:0] m_data = '0;

  function automatic int frame_len(int d);
    if (d >= 1 && d <= 10) return d * 8;
    return 80;
  endfunction

  function automatic int where_com(int s, int kk, bit rev);
    if (!rev) return (s + kk) % NC;
    return (2 * NC - 1 - s - kk) % NC;
  endfunction

  function automatic int find_sel(logic [2*NC-1:0] cc);
    int idx = -1, cnt = 0;
    for (int i = 0; i < NC; i++)
      if (cc[2*i +: 2] < 2) begin idx = i; cnt++; end
    return (cnt == 1) ? idx : -1;
  endfunction

  task automatic check(bit ok, string req, logic [263:0] act, logic [263:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [2*NC-1:0] ec;
    logic [2*NS-1:0] es;
    bit blank_m, pix;
    blank_m = master ? disp_off : doff_in;
    for (int i = 0; i < NC; i++) begin
      bit sel = (m_valid != 0) && (i == m_com);
      if (power_save)           ec[2*i +: 2] = 2'd0;
      else if (sel && m_fr)     ec[2*i +: 2] = 2'd0;
      else if (sel)             ec[2*i +: 2] = 2'd1;
      else if (m_fr != 0)       ec[2*i +: 2] = 2'd2;
      else                      ec[2*i +: 2] = 2'd3;
    end
    for (int j = 0; j < NS; j++) begin
      pix = blank_m ? 1'b0 : (m_data[j] ^ invert);
      if (power_save)            es[2*j +: 2] = 2'd0;
      else if (pix && m_fr != 0) es[2*j +: 2] = 2'd1;
      else if (pix)              es[2*j +: 2] = 2'd0;
      else if (m_fr != 0)        es[2*j +: 2] = 2'd2;
      else                       es[2*j +: 2] = 2'd3;
    end
    check(int'(rd_line) == (int'(start_line) + k) % NC, "R2 rd_line", 264'(rd_line),
          264'((int'(start_line) + k) % NC));
    check(fr_out == fr_m[0], "R1 fr_out", 264'(fr_out), 264'(fr_m[0]));
    check(doff_out == disp_off, "R9 doff_out", 264'(doff_out), 264'(disp_off));
    check(com_code == ec, "R3/R5 com_code", 264'(com_code), 264'(ec));
    check(seg_code == es, "R4/R7/R8 seg_code", seg_code, es);
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      k = 0; fr_m = 0; m_com = 0; m_fr = 0; m_valid = 0; m_data = '0;
    end else if (tick) begin
      for (int j = 0; j < NS; j++) m_data[j] = pat((int'(start_line) + k) % NC, j);
      m_com   = where_com(int'(start_com), k, com_rev);
      m_fr    = master ? fr_m : int'(fr_in);
      m_valid = 1;
      if (k >= frame_len(int'(duty_sel)) - 1) begin k = 0; fr_m ^= 1; end
      else k++;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic restart();
    rst_n = 1'b0; tick = 1'b0; step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2*NC-1:0] hold_c;
    logic [2*NS-1:0] hold_s;
    logic [6:0]      hold_l;
    rst_n = 0; tick = 0; master = 1; fr_in = 0; doff_in = 0; duty_sel = 4'd1;
    start_line = 0; start_com = 0; com_rev = 0; invert = 0; disp_off = 0; power_save = 0;
    @(negedge clk);
    repeat (3) step();
    // R10: reset state, nothing selected, pixels zero at phase 0
    check(com_code == {NC{2'd3}}, "R10 commons unselected", 264'(com_code), 264'({NC{2'd3}}));
    check(seg_code == {NS{2'd3}}, "R10 pixels cleared", seg_code, {NS{2'd3}});
    check(fr_out == 1'b0 && rd_line == 7'd0, "R10 scan origin", 264'({fr_out, rd_line}), 264'(0));

    // R1: 8-line frame flips alternation after 8 ticks
    rst_n = 1; tick = 1;
    repeat (8) step();
    check(fr_out == 1'b1, "R1 flip after 8 ticks", 264'(fr_out), 264'(1));
    repeat (7) step();
    check(fr_out == 1'b1, "R1 hold inside frame", 264'(fr_out), 264'(1));
    step();
    check(fr_out == 1'b0, "R1 second flip", 264'(fr_out), 264'(0));

    // R2/R3: offsets with wrap, normal order
    start_line = 7'd75; start_com = 7'd70; duty_sel = 4'd10;
    restart(); tick = 1; step();
    check(find_sel(com_code) == 70, "R3 first line on start common", 264'(find_sel(com_code)), 264'(70));
    check(rd_line == 7'd76, "R2 next line address", 264'(rd_line), 264'(76));
    for (int i = 0; i < 200; i++) begin tick = (i % 3 != 2); step(); end

    // R3: reversed order puts the first line on the last common
    com_rev = 1; start_com = 7'd0; duty_sel = 4'd3;
    restart(); tick = 1; step();
    check(find_sel(com_code) == 79, "R3 reversed top on last common", 264'(find_sel(com_code)), 264'(79));
    // R7: invert over a 24-line partial frame
    invert = 1; start_com = 7'd3;
    for (int i = 0; i < 100; i++) begin tick = (i % 4 != 0); step(); end

    // R11: no tick, nothing moves
    tick = 0; step();
    hold_c = com_code; hold_s = seg_code; hold_l = rd_line;
    repeat (5) step();
    check(com_code == hold_c && seg_code == hold_s && rd_line == hold_l, "R11 idle hold",
          264'(rd_line), 264'(hold_l));

    // R1: out-of-range duty codes give 80 lines
    invert = 0; com_rev = 0; duty_sel = 4'd0; tick = 1;
    repeat (170) step();
    duty_sel = 4'd15; repeat (90) step();

    // R8: blanking forces pixel 0 codes
    disp_off = 1; repeat (20) step();
    begin
      bit ok = 1;
      for (int j = 0; j < NS; j++) if (seg_code[2*j +: 2] < 2) ok = 0;
      check(ok, "R8 blank shows no lit pixel", seg_code, {NS{2'd3}});
    end
    disp_off = 0; repeat (5) step();

    // R6: power-save drives everything to VSS
    power_save = 1; repeat (10) step();
    check(com_code == '0 && seg_code == '0, "R6 all VSS", seg_code, '0);
    power_save = 0;

    // R9: slave mode takes phase and blank from inputs
    master = 0;
    for (int i = 0; i < 60; i++) begin
      fr_in = (i / 5) % 2; doff_in = (i / 13) % 2; step();
    end
    fr_in = 1; doff_in = 0; tick = 1; step();
    check(com_code[2*find_sel(com_code) +: 2] == 2'd0, "R9 slave phase from input",
          264'(com_code[2*find_sel(com_code) +: 2]), 264'(0));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule